// File: doc/BRIEF.md
# Prescaled reference-compare timer

This block is a 16-bit up-counter behind a small register window. A programmable prescaler divides the system clock by 1 to 256. The divided ticks step the counter. When the counter holds the value of the reference register at a tick, it returns to zero and sets a latched reference event flag. That flag, gated by an enable bit in the mode register, drives a level interrupt.

Software sets the divisor, the tick source and the interrupt enable through the mode register, and the compare value through the reference register. It can preload or read the live count through the counter register and acknowledge the event by writing a one to it. Clearing the enable bit of the mode register after it was set returns the whole timer to its idle state.

Top module: `ref_cmp_timer`

## Requirements
- R1: After reset the mode register (offset 0x00) reads 0x0000, the reference register (0x04) reads 0xFFFF, the counter (0x0C) reads 0x0000, the event register (0x11) reads 0x0000 and irq is low.
- R2: With counting enabled, the counter advances by one every (mode[15:8] + 1) clock cycles, counted from the write to the mode register.
- R3: The counter advances only while mode bit 0 is 1 and the source field mode[2:1] equals 1 or 2; with the field at 0 or 3, or bit 0 at 0, the count holds its value.
- R4: At a tick where the count equals the reference value, the count becomes 0 and event bit 1 is set; counting then continues from 0, so the event is first set (ref+1)*(mode[15:8]+1) cycles after the mode write.
- R5: irq is high exactly when mode bit 4 is 1 and event bit 1 is set.
- R6: Writing the event register with bit 1 = 1 clears event bit 1; writing it with bit 1 = 0 leaves the flag unchanged.
- R7: A write to the counter register loads the written value into the count on that clock edge.
- R8: Any write to the mode or reference register sets the count to 0 and restarts the prescaler.
- R9: A mode write that takes bit 0 from 1 to 0 clears the count and the event flag and returns the reference register to 0xFFFF; a mode write with bit 0 already 0 leaves the reference register as it was.
- R10: The capture register (0x08) always reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per register write |
| bus_addr | input | 5 | Byte offset within the 32-byte register window |
| bus_wdata | input | 16 | Write data; the event register uses bits 7:0 |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Reference-match interrupt, level |

## Verification
A prescaler phase or count that is off by one shows in the live counter read within one divided period. After the reference compare the error is latched into the event flag and irq, so an early or late wrap is seen at those ports at the matching edge. A wrong restart or soft-reset action leaves a nonzero count or a stale reference value, and the read on the next cycle shows it. The directed checks therefore read the count at exact cycle offsets from the write that started counting, where any deviation of one tick is visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 5;

    // register offsets within the window
    localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] A_REF  = 5'h04;
    localparam logic [ADDR_W-1:0] A_CAP  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EVT  = 5'h11;

    // mode register fields
    localparam int MB_EN     = 0;
    localparam int MB_SRC_LO = 1;
    localparam int MB_IE     = 4;
    localparam int MB_PRE_LO = 8;

    // event register field
    localparam int EB_REF = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick = run && !restart && (pre_q == div_m1);
        if (restart || !run || tick) pre_d = '0;
        else                         pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: with a divisor above one, ticks never come back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_m1 != '0) |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        match   = tick && !clear && !load && (count_q == limit);
        count_d = count_q;
        if (clear)      count_d = '0;
        else if (load)  count_d = load_val;
        else if (match) count_d = '0;
        else if (tick)  count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R4: a tick at the reference value sends the count back to zero
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !load && count_q == limit) |=> (count_q == '0));

    // R2: an ordinary tick steps the count by one
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && !load && count_q != limit) |=> (count_q == $past(count_q) + 1'b1));

    // R3: without a tick or a write the count is frozen
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !load) |=> $stable(count_q));

    // R7: a load lands on the next edge
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (count_q == $past(load_val)));
endmodule

// File: rtl/ref_cmp_timer.sv
module ref_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int MODE_W = MB_PRE_LO + PRE_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  limit;
        logic              evt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             wr_mode, wr_ref, wr_cnt, wr_evt;
    logic             hard_clr, restart, run, tick, match;
    logic [1:0]       src;
    logic [CNT_W-1:0] count;

    always_comb begin
        wr_mode  = bus_wr && (bus_addr == A_MODE);
        wr_ref   = bus_wr && (bus_addr == A_REF);
        wr_cnt   = bus_wr && (bus_addr == A_CNT);
        wr_evt   = bus_wr && (bus_addr == A_EVT);
        hard_clr = wr_mode && regs_q.mode[MB_EN] && !bus_wdata[MB_EN];
        restart  = wr_mode || wr_ref;
        src      = regs_q.mode[MB_SRC_LO +: 2];
        run      = regs_q.mode[MB_EN] && (src == 2'd1 || src == 2'd2);

        regs_d = regs_q;
        if (wr_mode) regs_d.mode = bus_wdata[MODE_W-1:0];
        if (hard_clr)    regs_d.limit = '1;
        else if (wr_ref) regs_d.limit = bus_wdata;
        if (hard_clr) regs_d.evt = 1'b0;
        else          regs_d.evt = (regs_q.evt && !(wr_evt && bus_wdata[EB_REF])) || match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mode  <= '0;
            regs_q.limit <= '1;
            regs_q.evt   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .div_m1  (regs_q.mode[MB_PRE_LO +: PRE_W]),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .limit    (regs_q.limit),
        .tick     (tick),
        .count    (count),
        .match    (match)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata = CNT_W'(regs_q.mode);
            A_REF:   bus_rdata = regs_q.limit;
            A_CNT:   bus_rdata = count;
            A_EVT:   bus_rdata[EB_REF] = regs_q.evt;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = regs_q.mode[MB_IE] & regs_q.evt;

    // R6: an acknowledge without a coincident match drops the flag
    assert_evt_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && bus_wdata[EB_REF] && !match) |=> !irq);

    // R9: soft reset restores the reference and empties the count
    assert_hard_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (regs_q.limit == '1 && count == '0 && !irq));

    // R8: mode or reference writes restart counting from zero
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    // R4: the flag rises only on the edge of a reference match
    assert_evt_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.evt && !match) |=> !regs_q.evt);
endmodule

// File: tb/tb_ref_cmp_timer.sv
`timescale 1ns/1ps
module tb_ref_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ref_cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  d;
        logic [1:0]  src;
        logic        ie;
        logic [15:0] r;
        logic [15:0] n;
        logic [15:0] exp_cnt;
        logic        exp_evt;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   2'd1, 1'b0, 16'd100, 16'd10,  16'd10, 1'b0, 1'b0},
        '{8'd3,   2'd2, 1'b1, 16'd100, 16'd40,  16'd10, 1'b0, 1'b0},
        '{8'd1,   2'd1, 1'b1, 16'd4,   16'd10,  16'd0,  1'b1, 1'b1},
        '{8'd0,   2'd1, 1'b0, 16'd3,   16'd6,   16'd2,  1'b1, 1'b0},
        '{8'd2,   2'd0, 1'b1, 16'd10,  16'd30,  16'd0,  1'b0, 1'b0},
        '{8'd2,   2'd3, 1'b1, 16'd10,  16'd30,  16'd0,  1'b0, 1'b0},
        '{8'd255, 2'd1, 1'b0, 16'd100, 16'd512, 16'd2,  1'b0, 1'b0},
        '{8'd0,   2'd1, 1'b1, 16'd0,   16'd5,   16'd0,  1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [15:0] mode_word(input logic [7:0] d, input logic [1:0] s, input logic ie);
        return {d, 3'b000, ie, 1'b1, s, 1'b1};
    endfunction

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); check("R1 mode", v, 16'h0000);
        rd(5'h04, v); check("R1 ref", v, 16'hFFFF);
        rd(5'h0C, v); check("R1 count", v, 16'h0000);
        rd(5'h11, v); check("R1 event", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);

        // R10 capture is read-only zero
        wr(5'h08, 16'h1234);
        rd(5'h08, v); check("R10 capture", v, 16'h0000);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            wr(5'h00, 16'h0000);
            wr(5'h04, VEC[i].r);
            wr(5'h00, mode_word(VEC[i].d, VEC[i].src, VEC[i].ie));
            repeat (int'(VEC[i].n)) @(posedge clk);
            @(negedge clk);
            rd(5'h0C, v); check($sformatf("R2/R3/R4 count vec%0d", i), v, VEC[i].exp_cnt);
            rd(5'h11, v); check($sformatf("R4 event vec%0d", i), v, {14'd0, VEC[i].exp_evt, 1'b0});
            check($sformatf("R5 irq vec%0d", i), {15'd0, irq}, {15'd0, VEC[i].exp_irq});
        end

        // R7 counter load while running
        wr(5'h00, 16'h0000);
        wr(5'h04, 16'd100);
        wr(5'h00, mode_word(8'd0, 2'd1, 1'b0));
        wr(5'h0C, 16'd50);
        rd(5'h0C, v); check("R7 load", v, 16'd50);
        repeat (7) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v); check("R7 count after load", v, 16'd57);

        // R8 reference write restarts
        wr(5'h04, 16'd100);
        rd(5'h0C, v); check("R8 restart", v, 16'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v); check("R8 count after restart", v, 16'd3);

        // R6 / R5 event acknowledge
        wr(5'h00, 16'h0000);
        wr(5'h04, 16'd2);
        wr(5'h00, mode_word(8'd0, 2'd1, 1'b1));
        repeat (5) @(posedge clk);
        @(negedge clk);
        wr(5'h00, mode_word(8'd0, 2'd0, 1'b0));
        rd(5'h11, v); check("R6 event set", v, 16'h0002);
        check("R5 irq gated off", {15'd0, irq}, 16'd0);
        wr(5'h00, mode_word(8'd0, 2'd0, 1'b1));
        check("R5 irq enabled", {15'd0, irq}, 16'd1);
        wr(5'h11, 16'h0000);
        rd(5'h11, v); check("R6 write zero keeps", v, 16'h0002);
        wr(5'h11, 16'h0002);
        rd(5'h11, v); check("R6 write one clears", v, 16'h0000);
        check("R6 irq low", {15'd0, irq}, 16'd0);

        // R9 soft reset, then R3 hold while disabled
        wr(5'h04, 16'd9);
        wr(5'h00, 16'h0000);
        rd(5'h04, v); check("R9 ref restored", v, 16'hFFFF);
        rd(5'h0C, v); check("R9 count cleared", v, 16'h0000);
        wr(5'h0C, 16'd7);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rd(5'h0C, v); check("R3 hold disabled", v, 16'd7);
        wr(5'h04, 16'd5);
        wr(5'h00, 16'h0000);
        rd(5'h04, v); check("R9 no reset 0 to 0", v, 16'd5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule